// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block produces the raster timing for a parallel synchronous display link. It runs from a master clock at twice the interface clock rate and puts out the divided interface clock together with horizontal sync, vertical sync, a data-enable flag, the index of the current pixel component and the current column and line counters. A pixel is carried as one or more interface-clock components, so the pixel period is the interface clock period times the programmed component count. Because the horizontal sync width is counted in master cycles, it has a resolution of half an interface clock.

All geometry is programmed at run time through a small parallel load port: an address, a data word and a write strobe. Writes land in a shadow copy. The working copy that drives the counters and decoders takes the shadow values only at the boundary between two frames, so a frame never changes shape halfway through. A line is the total line length in interface clocks, made up of a leading blank, an active run and a trailing blank. A frame is the total height in lines, made up of a leading blank, an active run of lines and a trailing blank.

Top module: `disp_timing_gen`

## Requirements
- R1: While `rst_n` is low, `col_cnt` and `line_cnt` are 0, `if_clk` is 0, `de` is 0, `comp_idx` is 0 and both syncs sit at their inactive level. After reset the polarity bits are 0, so both syncs are active-low and therefore read 1.
- R2: `if_clk` toggles on every master clock. `col_cnt` moves on once per interface clock, on the master edge that ends the high half of `if_clk`. Each column therefore spans two master cycles: the first with `if_clk` low, the second with it high.
- R3: `col_cnt` counts 0 to line length minus 1 and then wraps to 0. `line_cnt` advances on each wrap and counts 0 to frame height minus 1.
- R4: Horizontal sync is active from the first master cycle of column 0 for the number of master cycles set by the sync-width field, which counts half interface clocks. A width of 0 gives no pulse.
- R5: Vertical sync is active on every line whose number is below the vertical sync width in lines. It therefore starts in the same master cycle as the horizontal sync of line 0.
- R6: `de` is high exactly when `col_cnt` is in [leading blank, leading blank + active width) and `line_cnt` is in [top blank, top blank + active height).
- R7: If leading blank plus active width exceeds the line length, or top blank plus active height exceeds the frame height, `de` stays low for the whole frame.
- R8: While `de` is high, `comp_idx` equals (`col_cnt` − leading blank) modulo the component count. A count of 0 behaves as 1. While `de` is low, `comp_idx` is 0.
- R9: Polarity bit 0 selects the horizontal sync level and bit 1 the vertical sync level: 1 means active-high, 0 means active-low.
- R10: A register write changes only the shadow copy. The working copy loads the shadow on the master edge that ends the last master cycle of a frame, so a write takes effect from the first cycle of the next frame. A write in that same cycle waits one more frame.
- R11: Register addresses, each field taken from the low bits of `cfg_wdata`: 0 line length (12 bits), 1 leading blank (12), 2 active width (12), 3 horizontal sync width in half clocks (13), 4 frame height (11), 5 top blank (11), 6 active height (11), 7 vertical sync width in lines (11), 8 component count (3), 9 polarity (bit 0 horizontal, bit 1 vertical). Writes to addresses 10 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, twice the interface clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 13 | Register write data |
| if_clk | output | 1 | Interface clock, master clock divided by two |
| hsync | output | 1 | Horizontal sync, polarity programmable |
| vsync | output | 1 | Vertical sync, polarity programmable |
| de | output | 1 | Data enable, high during active pixels |
| comp_idx | output | 3 | Component index inside the current pixel |
| col_cnt | output | 12 | Current column in interface clocks |
| line_cnt | output | 11 | Current line |

## Verification
Every output is decoded from the counter state in the same master cycle, with no pipeline register in between, so each result is due in the cycle after the master edge that moved the counters. A register write is due at the first master cycle after the next frame boundary. The bench keeps a model built from a master-cycle position inside the frame plus its own shadow and working copies of the settings. The model steps on the same edges as the design, and the bench compares every output at the falling edge of each master cycle. Directed checks measure line length and the number of `de` cycles directly at the ports, before and after a frame boundary, to pin down when a write takes effect.

// File: rtl/disp_timing_pkg.sv
// Package: widths, register addresses and the configuration record shared by
// the display timing generator modules.
package disp_timing_pkg;

    parameter int COL_W  = 12;          // column counter width
    parameter int LINE_W = 11;          // line counter width
    parameter int CPP_W  = 3;           // component count / index width
    parameter int ADDR_W = 4;           // register address width
    localparam int DATA_W = COL_W + 1;  // widest field is the half-clock sync width

    typedef enum logic [ADDR_W-1:0] {
        RA_LINE_LEN  = 4'd0,
        RA_HLEAD     = 4'd1,
        RA_HACT      = 4'd2,
        RA_HSYNC_W   = 4'd3,
        RA_FRAME_HGT = 4'd4,
        RA_VLEAD     = 4'd5,
        RA_VACT      = 4'd6,
        RA_VSYNC_W   = 4'd7,
        RA_COMP_CNT  = 4'd8,
        RA_POLARITY  = 4'd9
    } reg_addr_e;

    typedef struct packed {
        logic [COL_W-1:0]  line_len;   // interface clocks per line
        logic [COL_W-1:0]  hlead;      // blank before active data
        logic [COL_W-1:0]  hact;       // active clocks per line
        logic [COL_W:0]    hsync_w;    // sync width in master cycles
        logic [LINE_W-1:0] frame_hgt;  // lines per frame
        logic [LINE_W-1:0] vlead;      // blank lines before active area
        logic [LINE_W-1:0] vact;       // active lines
        logic [LINE_W-1:0] vsync_w;    // vertical sync width in lines
        logic [CPP_W-1:0]  comp_cnt;   // components per pixel
        logic              hs_high;    // 1: hsync active-high
        logic              vs_high;    // 1: vsync active-high
    } timing_cfg_t;

endpackage

// File: rtl/disp_cfg_regs.sv
// Module: disp_cfg_regs
// Holds the shadow register set written through the load port and the
// working set used by the counters. The working set is refreshed from the
// shadow only when load_i pulses (end of frame). Assumes load_i is a
// single-cycle strobe from the scan counter.
module disp_cfg_regs
    import disp_timing_pkg::*;
#(
    parameter timing_cfg_t RST_CFG = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              load_i,
    output timing_cfg_t       work_o,
    output timing_cfg_t       next_o
);

    timing_cfg_t shadow_q;
    timing_cfg_t work_q;

    // Shadow update: one field per write, unknown addresses ignored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= RST_CFG;
        end else if (we_i) begin
            case (reg_addr_e'(addr_i))
                RA_LINE_LEN:  shadow_q.line_len  <= wdata_i[COL_W-1:0];
                RA_HLEAD:     shadow_q.hlead     <= wdata_i[COL_W-1:0];
                RA_HACT:      shadow_q.hact      <= wdata_i[COL_W-1:0];
                RA_HSYNC_W:   shadow_q.hsync_w   <= wdata_i[COL_W:0];
                RA_FRAME_HGT: shadow_q.frame_hgt <= wdata_i[LINE_W-1:0];
                RA_VLEAD:     shadow_q.vlead     <= wdata_i[LINE_W-1:0];
                RA_VACT:      shadow_q.vact      <= wdata_i[LINE_W-1:0];
                RA_VSYNC_W:   shadow_q.vsync_w   <= wdata_i[LINE_W-1:0];
                RA_COMP_CNT:  shadow_q.comp_cnt  <= wdata_i[CPP_W-1:0];
                RA_POLARITY: begin
                    shadow_q.hs_high <= wdata_i[0];
                    shadow_q.vs_high <= wdata_i[1];
                end
                default: ;
            endcase
        end
    end

    // Working copy: refreshed from the shadow at the frame boundary only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q <= RST_CFG;
        end else if (load_i) begin
            work_q <= shadow_q;
        end
    end

    assign work_o = work_q;
    assign next_o = load_i ? shadow_q : work_q;

    // R10: outside a frame boundary the working set does not move.
    a_r10_work_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (work_q == $past(work_q)))
        else $error("a_r10_work_frozen");

endmodule

// File: rtl/disp_scan_ctr.sv
// Module: disp_scan_ctr
// Master-clock phase divider plus column, line and component counters.
// Phase 0 is the low half of the interface clock, phase 1 the high half;
// the counters step on the edge that ends phase 1. Assumes line length and
// frame height are at least 1 (0 makes every clock a wrap).
module disp_scan_ctr
    import disp_timing_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COL_W-1:0]  line_len_i,
    input  logic [LINE_W-1:0] frame_hgt_i,
    input  logic [COL_W-1:0]  next_hlead_i,
    input  logic [CPP_W-1:0]  comp_cnt_i,
    output logic              phase_o,
    output logic [COL_W-1:0]  col_o,
    output logic [LINE_W-1:0] line_o,
    output logic [CPP_W-1:0]  comp_o,
    output logic              frame_end_o
);

    logic              phase_q;
    logic [COL_W-1:0]  col_q;
    logic [LINE_W-1:0] line_q;
    logic [CPP_W-1:0]  comp_q;

    logic [COL_W:0]    col_inc;
    logic [LINE_W:0]   line_inc;
    logic [CPP_W:0]    comp_inc;
    logic              col_last, line_last, comp_wrap;
    logic [COL_W-1:0]  col_next;

    // Wrap detection for the column, line and component counters.
    always_comb begin
        col_inc   = {1'b0, col_q} + (COL_W+1)'(1);
        line_inc  = {1'b0, line_q} + (LINE_W+1)'(1);
        comp_inc  = {1'b0, comp_q} + (CPP_W+1)'(1);
        col_last  = col_inc >= {1'b0, line_len_i};
        line_last = line_inc >= {1'b0, frame_hgt_i};
        comp_wrap = comp_inc >= {1'b0, comp_cnt_i};
        col_next  = col_last ? '0 : col_inc[COL_W-1:0];
    end

    assign frame_end_o = phase_q && col_last && line_last;

    // Phase divider and raster counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            col_q   <= '0;
            line_q  <= '0;
            comp_q  <= '0;
        end else begin
            phase_q <= ~phase_q;
            if (phase_q) begin
                col_q <= col_next;
                if (col_last) begin
                    line_q <= line_last ? '0 : line_inc[LINE_W-1:0];
                end
                if (col_next == next_hlead_i) begin
                    comp_q <= '0;
                end else begin
                    comp_q <= comp_wrap ? '0 : comp_inc[CPP_W-1:0];
                end
            end
        end
    end

    assign phase_o = phase_q;
    assign col_o   = col_q;
    assign line_o  = line_q;
    assign comp_o  = comp_q;

    // R2: the interface clock phase alternates on every master edge.
    a_r2_phase_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (phase_q != $past(phase_q)))
        else $error("a_r2_phase_toggle");

    // R3: counters only move at the end of the high half.
    a_r3_hold_low_half: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_q |=> ($stable(col_q) && $stable(line_q)))
        else $error("a_r3_hold_low_half");

    // R3: column stays inside the programmed line.
    a_r3_col_range: assert property (@(posedge clk) disable iff (!rst_n)
        (line_len_i != '0) |-> (col_q < line_len_i))
        else $error("a_r3_col_range");

endmodule

// File: rtl/disp_sync_dec.sv
// Module: disp_sync_dec
// Decodes sync pulses, data enable and component index from the counter
// state and the working configuration. Purely combinational apart from the
// clocked checks; outputs are forced inactive while reset is asserted.
module disp_sync_dec
    import disp_timing_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  timing_cfg_t       cfg_i,
    input  logic              phase_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic [CPP_W-1:0]  comp_i,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic [CPP_W-1:0]  comp_idx_o
);

    logic [COL_W:0]  hpos;
    logic [COL_W:0]  hend;
    logic [LINE_W:0] vend;
    logic            hs_act, vs_act, fits, in_h, in_v;

    // Sync windows, geometry sanity and active-area decode.
    always_comb begin
        hpos   = {col_i, phase_i};
        hend   = {1'b0, cfg_i.hlead} + {1'b0, cfg_i.hact};
        vend   = {1'b0, cfg_i.vlead} + {1'b0, cfg_i.vact};
        hs_act = rst_n && (hpos < cfg_i.hsync_w);
        vs_act = rst_n && (line_i < cfg_i.vsync_w);
        fits   = (hend <= {1'b0, cfg_i.line_len}) && (vend <= {1'b0, cfg_i.frame_hgt});
        in_h   = (col_i >= cfg_i.hlead) && ({1'b0, col_i} < hend);
        in_v   = (line_i >= cfg_i.vlead) && ({1'b0, line_i} < vend);
    end

    assign hsync_o    = cfg_i.hs_high ? hs_act : ~hs_act;
    assign vsync_o    = cfg_i.vs_high ? vs_act : ~vs_act;
    assign de_o       = rst_n && fits && in_h && in_v;
    assign comp_idx_o = de_o ? comp_i : '0;

    // R5: vertical sync begins together with the first master cycle of line 0.
    a_r5_vs_align: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vs_act) |-> (line_i == '0 && col_i == '0 && !phase_i))
        else $error("a_r5_vs_align");

    // R8: component index stays below the programmed count.
    a_r8_comp_range: assert property (@(posedge clk) disable iff (!rst_n)
        de_o |-> ((cfg_i.comp_cnt == '0) ? (comp_idx_o == '0) : (comp_idx_o < cfg_i.comp_cnt)))
        else $error("a_r8_comp_range");

    // R6: data enable only inside the programmed rows.
    a_r6_de_rows: assert property (@(posedge clk) disable iff (!rst_n)
        de_o |-> (line_i >= cfg_i.vlead && line_i < cfg_i.frame_hgt))
        else $error("a_r6_de_rows");

endmodule

// File: rtl/disp_timing_gen.sv
// Module: disp_timing_gen (top)
// Programmable raster timing generator for a parallel synchronous display
// link. Runs from a master clock at twice the interface rate; all geometry
// comes from shadowed registers loaded at frame boundaries. Assumes the
// programmed line length and frame height are non-zero.
module disp_timing_gen
    import disp_timing_pkg::*;
#(
    parameter int DEF_LINE_LEN  = 32,
    parameter int DEF_HLEAD     = 4,
    parameter int DEF_HACT      = 20,
    parameter int DEF_HSYNC_W   = 6,
    parameter int DEF_FRAME_HGT = 12,
    parameter int DEF_VLEAD     = 2,
    parameter int DEF_VACT      = 8,
    parameter int DEF_VSYNC_W   = 1,
    parameter int DEF_COMP_CNT  = 1,
    parameter bit DEF_HS_HIGH   = 1'b0,
    parameter bit DEF_VS_HIGH   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              if_clk,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic [CPP_W-1:0]  comp_idx,
    output logic [COL_W-1:0]  col_cnt,
    output logic [LINE_W-1:0] line_cnt
);

    localparam timing_cfg_t RST_CFG = '{
        line_len:  COL_W'(DEF_LINE_LEN),
        hlead:     COL_W'(DEF_HLEAD),
        hact:      COL_W'(DEF_HACT),
        hsync_w:   (COL_W+1)'(DEF_HSYNC_W),
        frame_hgt: LINE_W'(DEF_FRAME_HGT),
        vlead:     LINE_W'(DEF_VLEAD),
        vact:      LINE_W'(DEF_VACT),
        vsync_w:   LINE_W'(DEF_VSYNC_W),
        comp_cnt:  CPP_W'(DEF_COMP_CNT),
        hs_high:   DEF_HS_HIGH,
        vs_high:   DEF_VS_HIGH
    };

    timing_cfg_t       work_cfg, next_cfg;
    logic              phase, frame_end;
    logic [COL_W-1:0]  col;
    logic [LINE_W-1:0] line;
    logic [CPP_W-1:0]  comp;

    disp_cfg_regs #(.RST_CFG(RST_CFG)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .addr_i  (cfg_addr),
        .wdata_i (cfg_wdata),
        .load_i  (frame_end),
        .work_o  (work_cfg),
        .next_o  (next_cfg)
    );

    disp_scan_ctr u_scan (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_len_i   (work_cfg.line_len),
        .frame_hgt_i  (work_cfg.frame_hgt),
        .next_hlead_i (next_cfg.hlead),
        .comp_cnt_i   (work_cfg.comp_cnt),
        .phase_o      (phase),
        .col_o        (col),
        .line_o       (line),
        .comp_o       (comp),
        .frame_end_o  (frame_end)
    );

    disp_sync_dec u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_i      (work_cfg),
        .phase_i    (phase),
        .col_i      (col),
        .line_i     (line),
        .comp_i     (comp),
        .hsync_o    (hsync),
        .vsync_o    (vsync),
        .de_o       (de),
        .comp_idx_o (comp_idx)
    );

    assign if_clk   = phase;
    assign col_cnt  = col;
    assign line_cnt = line;

    // R1: while reset is applied the raster position is held at the origin.
    a_r1_reset_origin: assert property (@(posedge clk)
        !rst_n |=> (col == '0 && line == '0 && !phase))
        else $error("a_r1_reset_origin");

endmodule

// File: tb/disp_timing_gen_bench.sv
// Bench for disp_timing_gen: a frame-position model compared on every
// master cycle, directed corner cases and seeded random geometries.
module disp_timing_gen_bench;
    import disp_timing_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic [DATA_W-1:0] cfg_wdata = '0;
    logic              if_clk, hsync, vsync, de;
    logic [CPP_W-1:0]  comp_idx;
    logic [COL_W-1:0]  col_cnt;
    logic [LINE_W-1:0] line_cnt;

    always #2 clk = ~clk;   // 250 MHz

    disp_timing_gen u_disp_timing_gen (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .if_clk(if_clk), .hsync(hsync), .vsync(vsync),
        .de(de), .comp_idx(comp_idx), .col_cnt(col_cnt), .line_cnt(line_cnt)
    );

    int n_chk = 0, n_bad = 0, cyc = 0, loads = 0, m = 0;
    int mw[10], ms[10];
    bit chk_on = 0, done = 0;

    function automatic int def_val(int i);
        case (i)
            0: return 32; 1: return 4; 2: return 20; 3: return 6; 4: return 12;
            5: return 2;  6: return 8; 7: return 1;  8: return 1; default: return 0;
        endcase
    endfunction

    function automatic int fmask(int i);
        if (i <= 2) return 32'hFFF;
        if (i == 3) return 32'h1FFF;
        if (i <= 7) return 32'h7FF;
        if (i == 8) return 7;
        return 3;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    // Reference model: master-cycle position in the frame plus shadow/working sets.
    always @(posedge clk) begin
        if (!rst_n) begin
            m = 0;
            for (int i = 0; i < 10; i++) begin mw[i] = def_val(i); ms[i] = def_val(i); end
        end else begin
            if (m >= 2 * mw[0] * mw[4] - 1) begin
                m = 0;
                for (int i = 0; i < 10; i++) mw[i] = ms[i];
                loads++;
            end else begin
                m++;
            end
            if (cfg_we && cfg_addr < 10) ms[cfg_addr] = int'(cfg_wdata) & fmask(int'(cfg_addr));
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (chk_on) begin
            int len, col, line, cpp, hs_a, vs_a, de_e, comp_e, fits;
            len  = mw[0];
            col  = (m / 2) % len;
            line = (m / 2) / len;
            cpp  = (mw[8] == 0) ? 1 : mw[8];
            hs_a = (rst_n && (m % (2 * len)) < mw[3]) ? 1 : 0;
            vs_a = (rst_n && line < mw[7]) ? 1 : 0;
            fits = (mw[1] + mw[2] <= len && mw[5] + mw[6] <= mw[4]) ? 1 : 0;
            de_e = (rst_n && fits && col >= mw[1] && col < mw[1] + mw[2]
                    && line >= mw[5] && line < mw[5] + mw[6]) ? 1 : 0;
            comp_e = de_e ? (col - mw[1]) % cpp : 0;
            if (!rst_n) begin
                check("R1", "col_cnt", int'(col_cnt), 0);
                check("R1", "line_cnt", int'(line_cnt), 0);
                check("R1", "if_clk", int'(if_clk), 0);
                check("R1", "hsync", int'(hsync), 1);
                check("R1", "vsync", int'(vsync), 1);
                check("R1", "de", int'(de), 0);
            end else begin
                check("R2", "if_clk", int'(if_clk), m % 2);
                check("R3", "col_cnt", int'(col_cnt), col);
                check("R3", "line_cnt", int'(line_cnt), line);
                check("R4,R9", "hsync", int'(hsync), (mw[9] & 1) ? hs_a : 1 - hs_a);
                check("R5,R9", "vsync", int'(vsync), (mw[9] & 2) ? vs_a : 1 - vs_a);
                check(fits ? "R6" : "R7", "de", int'(de), de_e);
                check("R8", "comp_idx", int'(comp_idx), comp_e);
            end
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = ADDR_W'(a); cfg_wdata = DATA_W'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_loads(int n);
        int target;
        target = loads + n;
        while (loads < target) @(negedge clk);
        @(negedge clk);
    endtask

    // Waits for the start of a line at the ports and returns its largest column.
    task automatic line_max_col(output int mx);
        while (!(col_cnt == 0 && if_clk == 1'b0)) @(negedge clk);
        mx = 0;
        @(negedge clk);
        while (!(col_cnt == 0 && if_clk == 1'b0)) begin
            if (int'(col_cnt) > mx) mx = int'(col_cnt);
            @(negedge clk);
        end
    endtask

    // Counts de-high master cycles over one whole frame starting at line 0.
    task automatic frame_de_count(int frame_cycles, output int cnt);
        while (!(col_cnt == 0 && line_cnt == 0 && if_clk == 1'b0)) @(negedge clk);
        cnt = 0;
        for (int i = 0; i < frame_cycles; i++) begin
            if (de) cnt++;
            @(negedge clk);
        end
    endtask

    task automatic load_all(int v[10]);
        for (int i = 0; i < 10; i++) begin
            wr(i, v[i]);
            repeat ($urandom % 20) @(negedge clk);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected=<190000", cyc);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int mx, cnt;
        int va[10];
        void'($urandom(32'h5EED_0D15));
        @(posedge clk);
        chk_on = 1;
        repeat (4) @(negedge clk);            // R1: reset state checked per cycle
        rst_n = 1'b1;
        wait_loads(2);                         // default geometry

        // Directed: odd half-clock sync width, 3 components, hsync active-high.
        va = '{10, 2, 6, 3, 6, 1, 3, 2, 3, 1};
        load_all(va);
        wait_loads(2);
        line_max_col(mx);
        check("R3", "line max column", mx, 9);

        // R10: mid-frame write of line length waits for the frame boundary.
        while (line_cnt != 1) @(negedge clk);
        wr(0, 7);
        line_max_col(mx);
        check("R10", "max column before boundary", mx, 9);
        wait_loads(1);
        line_max_col(mx);
        check("R10", "max column after boundary", mx, 6);

        // R7: horizontal overflow (2+6 > 7) keeps de low for a whole frame.
        wr(2, 6);
        wait_loads(2);
        frame_de_count(2 * 7 * 6, cnt);
        check("R7", "de cycles, horizontal overflow", cnt, 0);
        // R7: vertical overflow (1+6 > 6).
        wr(2, 3); wr(6, 6);
        wait_loads(2);
        frame_de_count(2 * 7 * 6, cnt);
        check("R7", "de cycles, vertical overflow", cnt, 0);
        // R6: restored geometry gives 3 lines x 3 columns x 2 master cycles.
        wr(6, 3);
        wait_loads(2);
        frame_de_count(2 * 7 * 6, cnt);
        check("R6", "de cycles, valid frame", cnt, 18);

        // Corners: no hsync pulse, component count 0, vsync width 0, swapped polarity.
        wr(3, 0); wr(8, 0); wr(7, 0); wr(9, 2);
        wait_loads(2);

        // R11: unused addresses change nothing.
        wr(12, 3); wr(15, 8191); wr(10, 1);
        wait_loads(2);
        line_max_col(mx);
        check("R11", "line length after unused writes", mx, 6);

        // Random geometries, some deliberately overflowing.
        for (int k = 0; k < 40; k++) begin
            int len, hgt;
            len = 1 + $urandom % 24;
            hgt = 1 + $urandom % 12;
            va[0] = len;
            va[1] = $urandom % (len + 1);
            va[2] = ($urandom % 5 == 0) ? len - va[1] + 1 + $urandom % 3
                                        : $urandom % (len - va[1] + 1);
            va[3] = $urandom % (2 * len + 1);
            va[4] = hgt;
            va[5] = $urandom % (hgt + 1);
            va[6] = ($urandom % 5 == 0) ? hgt - va[5] + 1 + $urandom % 3
                                        : $urandom % (hgt - va[5] + 1);
            va[7] = $urandom % (hgt + 1);
            va[8] = $urandom % 8;
            va[9] = $urandom % 4;
            load_all(va);
            wait_loads(2);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule